// File: doc/BRIEF.md
# Reservation Monitor for Atomic Load/Store Pairs

This block guards a single processor's atomic read-modify-write sequence. A reserving load reads a word, returns it to the register file, and arms a reservation on that word's physical address. A later conditional store is allowed to reach memory only if the reservation is still armed and targets the same word. The register file then receives 1 for success or 0 for failure in place of the stored data, and software loops back to the reserving load whenever it reads 0.

While the reservation is armed, the block watches a snoop port that carries writes made by other processors and devices. Any such write that lands anywhere inside the reserved word cancels the reservation. An exception-return pulse also cancels it.

The address is the base register value plus a sign-extended 16-bit offset. Translation happens upstream, so this address is treated as physical. Memory reads are synchronous: read data arrives in the cycle after the request, and register write-back happens in that same cycle.

Top module: `llsc_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it, no register write takes place. The reservation is disarmed, so a conditional store issued first after reset writes nothing to memory and returns 0.
- R2: For a request with `req_op` equal to 1 (reserving load) or 2 (conditional store), `mem_addr` equals `req_base` plus `req_ofs` sign-extended to the address width, in the same cycle.
- R3: A reserving load raises `mem_rd_en`. One cycle later it writes the word from `mem_rdata` to the register file. With `req_wide` set, bit 31 of that word is copied into bits 63..32; with `req_wide` clear, bits 63..32 are zero.
- R4: A conditional store whose address lies in the reserved word (address bits 31..2 equal), while the reservation is armed, raises `mem_wr_en` with `mem_wdata` equal to `req_sdata`. One cycle later it writes the value 1 to the register file.
- R5: A conditional store with no armed reservation, or aimed at a different word, keeps `mem_wr_en` low and writes 0 to the register file.
- R6: Every conditional store disarms the reservation, so a second conditional store to the same word fails.
- R7: A snoop write (`snoop_valid`) whose address bits 31..2 match the reserved word disarms the reservation, whatever its bits 1..0 are. A snoop write to another word leaves it armed.
- R8: A snoop write that hits the reserved word in the same cycle as a conditional store makes that store fail.
- R9: `eret_pulse` disarms the reservation. A conditional store in the same cycle as the pulse fails.
- R10: A reserving load replaces any earlier reservation with its own word. If a snoop write hits that same word in the cycle of the load, the new reservation is left disarmed.
- R11: The register write for a request occurs exactly one cycle after it, to index `req_dest`. `req_op` values 0 and 3 cause neither a memory access nor a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | 0 idle, 1 reserving load, 2 conditional store, 3 idle |
| req_base | input | AW | Base register value |
| req_ofs | input | 16 | Signed address offset |
| req_dest | input | 5 | Destination register index |
| req_wide | input | 1 | Sign-extend loaded word to full register width |
| req_sdata | input | WW | Data for conditional store |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address for memory |
| mem_wdata | output | WW | Memory write data |
| mem_rdata | input | WW | Memory read data, one cycle after read strobe |
| snoop_valid | input | 1 | A write by another agent is visible this cycle |
| snoop_addr | input | AW | Byte address of that write |
| eret_pulse | input | 1 | Exception return, cancels reservation |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wdata | output | DW | Register file write data |

## Verification
The assertions assume that `rst` is driven high at the first clock edge. They also assume that `req_op`, snoop and exception-return inputs change only between edges, and that the memory honours the one-cycle read latency. The stimulus drives every input on the falling edge. Its memory model answers reads on the next rising edge. It draws addresses from four neighbouring words with offsets that include unaligned byte positions, so that reservations, snoop hits and same-word conditional stores recur often, and it mixes in same-cycle collisions of snoop, exception return and store.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int REG_IDX_W = 5;
    localparam int OFS_W     = 16;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_STORE = 2'd2,
        OP_SPARE = 2'd3
    } llsc_op_e;

    typedef struct packed {
        logic                 valid;
        logic                 is_load;
        logic                 wide;
        logic                 sc_ok;
        logic [REG_IDX_W-1:0] dest;
    } wb_rec_t;

    function automatic logic is_load(input logic [1:0] op);
        return op == OP_LOAD;
    endfunction

    function automatic logic is_store(input logic [1:0] op);
        return op == OP_STORE;
    endfunction

endpackage

// File: rtl/llsc_addr_gen.sv
module llsc_addr_gen
    import llsc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    base,
    input  logic [OFS_W-1:0] ofs,
    output logic [AW-1:0]    ea,
    output logic [AW-3:0]    ea_word
);
    localparam int EXT_W = AW - OFS_W;

    logic [AW-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        ea      = base + ofs_ext;
        ea_word = ea[AW-1:2];
    end
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg
    import llsc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op,
    input  logic [AW-3:0] ea_word,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          eret_pulse,
    output logic          sc_pass,
    output logic          link_q,
    output logic [AW-3:0] link_word_q
);
    localparam int WAW = AW - 2;

    logic [AW-1:0] snoop_word_full;
    logic          snoop_on_link;
    logic          snoop_on_req;
    logic          link_d;
    logic [WAW-1:0] word_d;

    always_comb begin
        snoop_word_full = snoop_addr >> 2;
        snoop_on_link   = snoop_valid && link_q &&
                          (snoop_word_full == {2'b00, link_word_q});
        snoop_on_req    = snoop_valid &&
                          (snoop_word_full == {2'b00, ea_word});
        sc_pass = is_store(op) && link_q && (ea_word == link_word_q) &&
                  !snoop_on_link && !eret_pulse;

        link_d = link_q;
        word_d = link_word_q;
        if (eret_pulse) begin
            link_d = 1'b0;
        end else if (is_load(op)) begin
            link_d = !snoop_on_req;
            word_d = ea_word;
        end else if (is_store(op) || snoop_on_link) begin
            link_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q      <= 1'b0;
            link_word_q <= '0;
        end else begin
            link_q      <= link_d;
            link_word_q <= word_d;
        end
    end
endmodule

// File: rtl/llsc_wb.sv
module llsc_wb
    import llsc_pkg::*;
#(
    parameter int DW = 64,
    parameter int WW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           op,
    input  logic                 wide,
    input  logic                 sc_pass,
    input  logic [REG_IDX_W-1:0] dest,
    input  logic [WW-1:0]        mem_rdata,
    output logic                 rf_wr_en,
    output logic [REG_IDX_W-1:0] rf_wr_idx,
    output logic [DW-1:0]        rf_wdata
);
    localparam int PAD_W = DW - WW;

    wb_rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q.valid   <= is_load(op) || is_store(op);
            rec_q.is_load <= is_load(op);
            rec_q.wide    <= wide;
            rec_q.sc_ok   <= sc_pass;
            rec_q.dest    <= dest;
        end
    end

    always_comb begin
        rf_wr_en  = rec_q.valid;
        rf_wr_idx = rec_q.dest;
        if (rec_q.is_load) begin
            rf_wdata = {{PAD_W{rec_q.wide & mem_rdata[WW-1]}}, mem_rdata};
        end else begin
            rf_wdata = {{(DW-1){1'b0}}, rec_q.sc_ok};
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int WW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           req_op,
    input  logic [AW-1:0]        req_base,
    input  logic [OFS_W-1:0]     req_ofs,
    input  logic [REG_IDX_W-1:0] req_dest,
    input  logic                 req_wide,
    input  logic [WW-1:0]        req_sdata,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic [AW-1:0]        mem_addr,
    output logic [WW-1:0]        mem_wdata,
    input  logic [WW-1:0]        mem_rdata,
    input  logic                 snoop_valid,
    input  logic [AW-1:0]        snoop_addr,
    input  logic                 eret_pulse,
    output logic                 rf_wr_en,
    output logic [REG_IDX_W-1:0] rf_wr_idx,
    output logic [DW-1:0]        rf_wdata
);
    logic [AW-3:0] ea_word;
    logic          sc_pass;
    logic          link_q;
    logic [AW-3:0] link_word_q;

    llsc_addr_gen #(.AW(AW)) agen_i (
        .base    (req_base),
        .ofs     (req_ofs),
        .ea      (mem_addr),
        .ea_word (ea_word)
    );

    llsc_link_reg #(.AW(AW)) link_i (
        .clk         (clk),
        .rst         (rst),
        .op          (req_op),
        .ea_word     (ea_word),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .eret_pulse  (eret_pulse),
        .sc_pass     (sc_pass),
        .link_q      (link_q),
        .link_word_q (link_word_q)
    );

    llsc_wb #(.DW(DW), .WW(WW)) wb_i (
        .clk       (clk),
        .rst       (rst),
        .op        (req_op),
        .wide      (req_wide),
        .sc_pass   (sc_pass),
        .dest      (req_dest),
        .mem_rdata (mem_rdata),
        .rf_wr_en  (rf_wr_en),
        .rf_wr_idx (rf_wr_idx),
        .rf_wdata  (rf_wdata)
    );

    always_comb begin
        mem_rd_en = is_load(req_op);
        mem_wr_en = sc_pass;
        mem_wdata = req_sdata;
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    req_op,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic          snoop_valid,
    input logic [AW-1:0] snoop_addr,
    input logic          eret_pulse,
    input logic          rf_wr_en,
    input logic          link_q,
    input logic [AW-3:0] link_word_q
);
    logic snoop_hits_link;
    assign snoop_hits_link = snoop_valid && link_q &&
                             (snoop_addr[AW-1:2] == link_word_q);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!link_q && !rf_wr_en));

    assert_write_needs_link_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (link_q && mem_addr[AW-1:2] == link_word_q));

    assert_store_disarms_R6: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd2) |=> !link_q);

    assert_snoop_disarms_R7: assert property (@(posedge clk) disable iff (rst)
        (snoop_hits_link && req_op != 2'd1) |=> !link_q);

    assert_snoop_blocks_store_R8: assert property (@(posedge clk) disable iff (rst)
        snoop_hits_link |-> !mem_wr_en);

    assert_eret_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        eret_pulse |=> !link_q);

    assert_wb_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd1 || req_op == 2'd2) |=> rf_wr_en);

    assert_idle_no_wb_R11: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd0 || req_op == 2'd3) |=> !rf_wr_en);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_op      (req_op),
    .mem_wr_en   (mem_wr_en),
    .mem_addr    (mem_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .eret_pulse  (eret_pulse),
    .rf_wr_en    (rf_wr_en),
    .link_q      (link_q),
    .link_word_q (link_word_q)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_base = '0;
    logic [15:0]   req_ofs = '0;
    logic [4:0]    req_dest = '0;
    logic          req_wide = 1'b0;
    logic [WW-1:0] req_sdata = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          eret_pulse = 1'b0;
    logic          rf_wr_en;
    logic [4:0]    rf_wr_idx;
    logic [DW-1:0] rf_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [WW-1:0] mem [16];
    logic          m_link;
    logic [AW-3:0] m_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.AW(AW), .DW(DW), .WW(WW)) dut_i (.*);

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[5:2]];
        if (mem_wr_en) mem[mem_addr[5:2]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge, check memory side, then write-back.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] base,
                         input logic [15:0] ofs, input logic [4:0] dest,
                         input logic wide, input logic [WW-1:0] sdata,
                         input logic snp_v, input logic [AW-1:0] snp_a,
                         input logic eret, input string tag);
        logic [AW-1:0] ea;
        logic [AW-3:0] w;
        logic snp_hit, exp_wr, is_ld, is_st;
        logic [WW-1:0] word;
        logic [DW-1:0] exp_data;
        ea = base + {{16{ofs[15]}}, ofs};
        w = ea[AW-1:2];
        is_ld = (op == 2'd1);
        is_st = (op == 2'd2);
        snp_hit = snp_v && m_link && (snp_a[AW-1:2] == m_word);
        exp_wr = is_st && m_link && (w == m_word) && !snp_hit && !eret;
        word = mem[ea[5:2]];
        if (is_ld) exp_data = wide ? {{32{word[31]}}, word} : {32'b0, word};
        else exp_data = {63'b0, exp_wr};

        req_op = op; req_base = base; req_ofs = ofs; req_dest = dest;
        req_wide = wide; req_sdata = sdata;
        snoop_valid = snp_v; snoop_addr = snp_a; eret_pulse = eret;
        #1;
        check(mem_wr_en === exp_wr, {tag, " mem_wr_en R4/R5"}, 64'(mem_wr_en), 64'(exp_wr));
        if (is_ld || is_st)
            check(mem_addr === ea, {tag, " mem_addr R2"}, 64'(mem_addr), 64'(ea));
        if (exp_wr)
            check(mem_wdata === sdata, {tag, " mem_wdata R4"}, 64'(mem_wdata), 64'(sdata));
        @(posedge clk);
        if (eret) m_link = 1'b0;
        else if (is_ld) begin
            m_link = !(snp_v && snp_a[AW-1:2] == w);
            m_word = w;
        end else if (is_st || snp_hit) m_link = 1'b0;
        #(CLK_PERIOD/2 - 1);
        req_op = 2'd0; snoop_valid = 1'b0; eret_pulse = 1'b0;
        if (is_ld || is_st) begin
            check(rf_wr_en === 1'b1, {tag, " rf_wr_en R11"}, 64'(rf_wr_en), 64'd1);
            check(rf_wr_idx === dest, {tag, " rf_wr_idx R11"}, 64'(rf_wr_idx), 64'(dest));
            check(rf_wdata === exp_data, {tag, is_ld ? " load data R3" : " sc result R4/R5"},
                  rf_wdata, exp_data);
        end else begin
            check(rf_wr_en === 1'b0, {tag, " idle no write R11"}, 64'(rf_wr_en), 64'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ofs_set [4];
        void'($urandom(32'd17));
        for (int i = 0; i < 16; i++) mem[i] = $urandom;
        mem[1] = 32'h8000_1234;
        m_link = 1'b0; m_word = '0;
        ofs_set[0] = 16'h0000; ofs_set[1] = 16'h0004;
        ofs_set[2] = 16'hFFFC; ofs_set[3] = 16'h0002;

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        check(rf_wr_en === 1'b0, "reset rf_wr_en R1", 64'(rf_wr_en), 64'd0);
        rst = 1'b0;
        @(posedge clk); #(CLK_PERIOD/2);
        check(rf_wr_en === 1'b0, "post reset rf_wr_en R1", 64'(rf_wr_en), 64'd0);

        // R1: store right after reset fails
        issue(2'd2, 32'h1004, 16'h0, 5'd3, 0, 32'hAAAA, 0, 0, 0, "R1 sc after reset");
        // R3: wide and narrow load of negative word
        issue(2'd1, 32'h1008, 16'hFFFC, 5'd4, 1, 0, 0, 0, 0, "R3 wide load");
        issue(2'd1, 32'h1004, 16'h0, 5'd5, 0, 0, 0, 0, 0, "R3 narrow load");
        // R4 then R6: store succeeds, second fails
        issue(2'd2, 32'h1006, 16'hFFFF, 5'd6, 0, 32'h1111_2222, 0, 0, 0, "R4 sc success");
        issue(2'd2, 32'h1004, 16'h0, 5'd7, 0, 32'h3333, 0, 0, 0, "R6 second sc");
        // R5: different word
        issue(2'd1, 32'h1010, 16'h0, 5'd8, 0, 0, 0, 0, 0, "R5 load");
        issue(2'd2, 32'h1014, 16'h0, 5'd8, 0, 32'h4444, 0, 0, 0, "R5 other word sc");
        // R7: snoop other word keeps, byte snoop in word breaks
        issue(2'd1, 32'h1010, 16'h0, 5'd9, 0, 0, 0, 0, 0, "R7 load");
        issue(2'd0, 0, 0, 0, 0, 0, 1, 32'h1014, 0, "R7 snoop other word");
        issue(2'd2, 32'h1010, 16'h0, 5'd9, 0, 32'h5555, 0, 0, 0, "R7 sc survives");
        issue(2'd1, 32'h1010, 16'h0, 5'd9, 0, 0, 0, 0, 0, "R7 reload");
        issue(2'd0, 0, 0, 0, 0, 0, 1, 32'h1013, 0, "R7 byte snoop");
        issue(2'd2, 32'h1010, 16'h0, 5'd9, 0, 32'h6666, 0, 0, 0, "R7 sc after snoop");
        // R8: snoop same cycle as store
        issue(2'd1, 32'h1000, 16'h0, 5'd10, 0, 0, 0, 0, 0, "R8 load");
        issue(2'd2, 32'h1000, 16'h0, 5'd10, 0, 32'h7777, 1, 32'h1001, 0, "R8 sc with snoop");
        // R9: eret alone and with store
        issue(2'd1, 32'h1000, 16'h0, 5'd11, 0, 0, 0, 0, 0, "R9 load");
        issue(2'd0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 eret");
        issue(2'd2, 32'h1000, 16'h0, 5'd11, 0, 32'h8888, 0, 0, 0, "R9 sc after eret");
        issue(2'd1, 32'h1000, 16'h0, 5'd11, 0, 0, 0, 0, 0, "R9 load2");
        issue(2'd2, 32'h1000, 16'h0, 5'd11, 0, 32'h9999, 0, 0, 1, "R9 sc with eret");
        // R10: load replaces; load with snoop on own word
        issue(2'd1, 32'h1000, 16'h0, 5'd12, 0, 0, 0, 0, 0, "R10 load A");
        issue(2'd1, 32'h1008, 16'h0, 5'd12, 0, 0, 0, 0, 0, "R10 load B");
        issue(2'd2, 32'h1000, 16'h0, 5'd12, 0, 32'hABCD, 0, 0, 0, "R10 sc old word");
        issue(2'd1, 32'h1008, 16'h0, 5'd13, 0, 0, 1, 32'h100A, 0, "R10 load snooped");
        issue(2'd2, 32'h1008, 16'h0, 5'd13, 0, 32'hBCDE, 0, 0, 0, "R10 sc fails");
        // R11: spare op code
        issue(2'd1, 32'h1008, 16'h0, 5'd14, 0, 0, 0, 0, 0, "R11 load");
        issue(2'd3, 32'h1008, 16'h0, 5'd14, 0, 32'h1, 0, 0, 0, "R11 spare op");
        issue(2'd2, 32'h1008, 16'h0, 5'd14, 0, 32'hCDEF, 0, 0, 0, "R11 sc after spare");

        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            logic [AW-1:0] b;
            logic sv, er;
            op = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) op = ($urandom_range(0, 1) == 1) ? 2'd1 : 2'd2;
            b = 32'h1000 + 32'(4 * $urandom_range(0, 3));
            sv = ($urandom_range(0, 9) < 3);
            er = ($urandom_range(0, 9) == 0);
            issue(op, b, ofs_set[$urandom_range(0, 3)], 5'($urandom), 1'($urandom),
                  $urandom, sv, 32'h1000 + 32'($urandom_range(0, 19)), er, "random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule